// File: doc/BRIEF.md
# Selectable EDAC and Parity Checker

This block guards a 16-bit memory data word as it crosses the processor bus. A control write picks one of four protection modes: off, single-error-correcting and double-error-detecting code (EDAC), even parity or odd parity. On memory write cycles the block places freshly computed check bits on the check bus. On memory read cycles it recomputes them from the returned word and compares the result with the check bits that memory returns. It corrects any single flipped bit in EDAC mode, and it reports uncorrectable words through an active-low error line while the cycle is in progress.

Two registers support diagnosis. One holds the most recent word that was corrected. The other holds the address of the first memory read that failed, and keeps it until software clears it. When an external memory controller asks the block to take over the data bus, the block drives the corrected word on the clock after the request. This gives the memory one cycle to release the bus. The bidirectional data, check and single-error pads are modelled as separate input, output and enable ports.

Top module: `mem_ecc_guard`

## Requirements
- R1: While `rst_n` is low and after reset is released, the mode is off: `mem_err_n` is 1, `sgl_err_oe` is 0, `chk_oe` is 0, `bus_oe` is 0 and `fail_valid` is 0.
- R2: A cycle with `ctl_we` high loads `ctl_mode` (00 off, 01 EDAC, 10 even parity, 11 odd parity), and the new mode applies from the next cycle. `sgl_err_oe` is 1 exactly when the mode is EDAC.
- R3: On an EDAC memory write (`cyc_valid`=1, `cyc_mem`=1, `cyc_rd`=0), `chk_oe`=1 and `chk_out` carries the code. To form it, data bit k sits at the (k+1)-th codeword position, counting from 1, that is not a power of two. Check bit i (0..4) is the XOR of the data bits whose position has bit i set. Check bit 5 is the XOR of all 16 data bits and check bits 0..4.
- R4: On an EDAC memory read whose data and check bits differ from a valid codeword in exactly one bit (data or check), `sgl_err` is 1 and `mem_err_n` stays 1 during that cycle.
- R5: On an EDAC memory read with two flipped bits, `mem_err_n` is 0 and `sgl_err` is 0 during that cycle.
- R6: On a parity-mode memory write, `chk_oe`=1, `chk_out[0]` makes the 17 bits (data plus `chk_out[0]`) even (mode 10) or odd (mode 11), and `chk_out[5:1]` is 0.
- R7: On a parity-mode memory read, `mem_err_n` is 0 during the cycle exactly when `bus_in` with `chk_in[0]` has the wrong parity for the mode. `chk_in[5:1]` is ignored.
- R8: After a clock edge that closes an EDAC memory read cycle with `ram_off`=1, `bus_oe` is 1 and `bus_out` is the corrected word for one cycle. After any other cycle `bus_oe` is 0.
- R9: At the edge that closes an EDAC memory read with a single error, `diag_word` loads the corrected word. No other cycle changes it.
- R10: The first failing memory read (single, double or parity error) loads `cyc_addr` into `fail_addr` and sets `fail_valid` at the closing edge. Later failures leave the register unchanged until a control write with `ctl_clr_fail`=1 clears `fail_valid`. A clear wins over a failure in the same cycle.
- R11: I/O cycles (`cyc_mem`=0), write cycles and off mode never drive `mem_err_n` low, never raise `sgl_err` and never set `fail_valid`. In off mode `chk_oe` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_mode | input | 2 | Protection mode written on `ctl_we` |
| ctl_clr_fail | input | 1 | With `ctl_we`, clears the first-failure register |
| cyc_valid | input | 1 | Bus cycle data phase active |
| cyc_mem | input | 1 | 1 memory cycle, 0 I/O cycle |
| cyc_rd | input | 1 | 1 read, 0 write |
| cyc_addr | input | ADDR_W | Address of the current cycle |
| ram_off | input | 1 | Memory has released the bus; drive corrected data next cycle |
| bus_in | input | DATA_W | Data bus as seen at the pads |
| bus_out | output | DATA_W | Corrected data driven onto the data bus |
| bus_oe | output | 1 | Data bus drive enable |
| chk_in | input | CHK_W | Check bus as seen at the pads |
| chk_out | output | CHK_W | Generated check bits |
| chk_oe | output | 1 | Check bus drive enable |
| mem_err_n | output | 1 | Active-low uncorrectable or parity error |
| sgl_err | output | 1 | Single corrected error flag |
| sgl_err_oe | output | 1 | Drive enable of `sgl_err` (low = high impedance) |
| diag_word | output | DATA_W | Last corrected word |
| fail_addr | output | ADDR_W | Address of the first failing read |
| fail_valid | output | 1 | `fail_addr` holds a capture |

## Verification
The bench flips single data bits, single check bits (including the overall-parity bit) and bit pairs, and compares each read against a codeword built independently from the position rule. A syndrome decoder that mixes up positions would correct the wrong bit and leave a bad `diag_word`. A decoder that ignores the overall parity would call double errors single. The bench sends a second and a third failure to new addresses and confirms that `fail_addr` keeps the first one until a clear. It then places an error-laden I/O read and an off-mode read, which a design decoding the cycle type wrongly would report or capture. The delayed bus drive is sampled both during the request cycle and after the edge, and each parity mode is checked with a `chk_in[5:1]` pattern that must be ignored.

// File: rtl/mem_ecc_pkg.sv
package mem_ecc_pkg;

   typedef enum logic [1:0] {
      GM_OFF      = 2'b00,
      GM_EDAC     = 2'b01,
      GM_PAR_EVEN = 2'b10,
      GM_PAR_ODD  = 2'b11
   } guard_mode_e;

   // Smallest r with 2^r >= dw + r + 1 (Hamming bound for single correction).
   function automatic int ham_width(input int dw);
      int r;
      r = 0;
      for (int t = 1; t < 16; t++) begin
         if (r == 0 && (1 << t) >= dw + t + 1) r = t;
      end
      return r;
   endfunction

endpackage

// File: rtl/ecc_codec.sv
module ecc_codec #(
   parameter int DATA_W = 16,
   localparam int HAM_W = mem_ecc_pkg::ham_width(DATA_W),
   localparam int CHK_W = HAM_W + 1
) (
   input  logic [DATA_W-1:0] wr_data,
   output logic [CHK_W-1:0]  gen_chk,
   input  logic [DATA_W-1:0] rd_data,
   input  logic [CHK_W-1:0]  rd_chk,
   output logic [DATA_W-1:0] corr_data,
   output logic              one_err,
   output logic              many_err
);

   localparam logic [HAM_W-1:0] LAST_POS = HAM_W'(DATA_W + HAM_W);

   // Codeword position of data bit k: the (k+1)-th non power of two.
   function automatic int pos_of(input int k);
      int cnt, res;
      cnt = 0;
      res = 0;
      for (int p = 3; p < 2 * DATA_W + 16; p++) begin
         if ((p & (p - 1)) != 0) begin
            if (cnt == k && res == 0) res = p;
            cnt++;
         end
      end
      return res;
   endfunction

   function automatic logic [DATA_W-1:0] cover_mask(input int i);
      logic [DATA_W-1:0] m;
      for (int k = 0; k < DATA_W; k++) m[k] = ((pos_of(k) >> i) & 1) == 1;
      return m;
   endfunction

   logic [HAM_W-1:0] ham_w;
   logic [HAM_W-1:0] ham_r;
   logic [HAM_W-1:0] syn;
   logic             odd_tot;
   logic             in_range;

   for (genvar i = 0; i < HAM_W; i++) begin : g_cover
      localparam logic [DATA_W-1:0] MASK = cover_mask(i);
      assign ham_w[i] = ^(wr_data & MASK);
      assign ham_r[i] = ^(rd_data & MASK);
   end

   assign gen_chk  = {(^wr_data) ^ (^ham_w), ham_w};

   assign syn      = ham_r ^ rd_chk[HAM_W-1:0];
   assign odd_tot  = ^{rd_data, rd_chk};
   assign in_range = (syn <= LAST_POS);

   assign one_err  = odd_tot & in_range;
   assign many_err = (~odd_tot & (|syn)) | (odd_tot & ~in_range);

   for (genvar k = 0; k < DATA_W; k++) begin : g_fix
      localparam logic [HAM_W-1:0] POS = HAM_W'(pos_of(k));
      assign corr_data[k] = rd_data[k] ^ (one_err & (syn == POS));
   end

endmodule

// File: rtl/parity_unit.sv
module parity_unit #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              rd_bit,
   input  logic              odd_sel,
   output logic              gen_bit,
   output logic              bad
);

   assign gen_bit = (^wr_data) ^ odd_sel;
   assign bad     = (^rd_data) ^ rd_bit ^ odd_sel;

endmodule

// File: rtl/fault_log.sv
module fault_log #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              fail_ev,
   input  logic [ADDR_W-1:0] addr,
   input  logic              corr_ev,
   input  logic [DATA_W-1:0] corr_word,
   output logic [ADDR_W-1:0] fail_addr,
   output logic              fail_valid,
   output logic [DATA_W-1:0] diag_word
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fail_valid <= 1'b0;
         fail_addr  <= '0;
      end else if (clr) begin
         fail_valid <= 1'b0;
      end else if (fail_ev && !fail_valid) begin
         fail_valid <= 1'b1;
         fail_addr  <= addr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       diag_word <= '0;
      else if (corr_ev) diag_word <= corr_word;
   end

endmodule

// File: rtl/mem_ecc_guard.sv
module mem_ecc_guard #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 20,
   localparam int CHK_W = mem_ecc_pkg::ham_width(DATA_W) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic [1:0]        ctl_mode,
   input  logic              ctl_clr_fail,
   input  logic              cyc_valid,
   input  logic              cyc_mem,
   input  logic              cyc_rd,
   input  logic [ADDR_W-1:0] cyc_addr,
   input  logic              ram_off,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_oe,
   input  logic [CHK_W-1:0]  chk_in,
   output logic [CHK_W-1:0]  chk_out,
   output logic              chk_oe,
   output logic              mem_err_n,
   output logic              sgl_err,
   output logic              sgl_err_oe,
   output logic [DATA_W-1:0] diag_word,
   output logic [ADDR_W-1:0] fail_addr,
   output logic              fail_valid
);
   import mem_ecc_pkg::*;

   if (DATA_W < 4) begin : g_bad_data
      $error("mem_ecc_guard: DATA_W must be at least 4");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("mem_ecc_guard: ADDR_W must be at least 1");
   end

   guard_mode_e       mode_q;
   logic              edac_on, par_on;
   logic              rd_cyc, wr_cyc;
   logic [CHK_W-1:0]  ecc_chk;
   logic [DATA_W-1:0] corr;
   logic              one_err, many_err;
   logic              par_bit, par_bad;
   logic              fail_ev, corr_ev, drive_ev;
   logic              drv_q;
   logic [DATA_W-1:0] drv_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mode_q <= GM_OFF;
      else if (ctl_we) mode_q <= guard_mode_e'(ctl_mode);
   end

   assign edac_on = (mode_q == GM_EDAC);
   assign par_on  = mode_q[1];
   assign rd_cyc  = cyc_valid & cyc_mem & cyc_rd;
   assign wr_cyc  = cyc_valid & cyc_mem & ~cyc_rd;

   ecc_codec #(.DATA_W(DATA_W)) u_codec (
      .wr_data   (bus_in),
      .gen_chk   (ecc_chk),
      .rd_data   (bus_in),
      .rd_chk    (chk_in),
      .corr_data (corr),
      .one_err   (one_err),
      .many_err  (many_err)
   );

   parity_unit #(.DATA_W(DATA_W)) u_par (
      .wr_data (bus_in),
      .rd_data (bus_in),
      .rd_bit  (chk_in[0]),
      .odd_sel (mode_q == GM_PAR_ODD),
      .gen_bit (par_bit),
      .bad     (par_bad)
   );

   // Check bus drive on memory writes.
   assign chk_oe  = wr_cyc & (edac_on | par_on);
   assign chk_out = edac_on ? ecc_chk : {{(CHK_W-1){1'b0}}, par_bit & par_on};

   // Read-side reporting.
   assign mem_err_n  = ~(rd_cyc & ((edac_on & many_err) | (par_on & par_bad)));
   assign sgl_err    = rd_cyc & edac_on & one_err;
   assign sgl_err_oe = edac_on;

   assign fail_ev  = rd_cyc & ((edac_on & (one_err | many_err)) | (par_on & par_bad));
   assign corr_ev  = rd_cyc & edac_on & one_err;
   assign drive_ev = rd_cyc & edac_on & ram_off;

   // Corrected data goes out one clock after the memory lets go of the bus.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drv_q    <= 1'b0;
         drv_word <= '0;
      end else begin
         drv_q <= drive_ev;
         if (drive_ev) drv_word <= corr;
      end
   end

   assign bus_oe  = drv_q;
   assign bus_out = drv_word;

   fault_log #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_log (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (ctl_we & ctl_clr_fail),
      .fail_ev    (fail_ev),
      .addr       (cyc_addr),
      .corr_ev    (corr_ev),
      .corr_word  (corr),
      .fail_addr  (fail_addr),
      .fail_valid (fail_valid),
      .diag_word  (diag_word)
   );

endmodule

// File: rtl/mem_ecc_guard_chk.sv
module mem_ecc_guard_chk #(
   parameter int ADDR_W = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ctl_we,
   input logic              ctl_clr_fail,
   input logic              cyc_valid,
   input logic              cyc_mem,
   input logic              cyc_rd,
   input logic              ram_off,
   input logic              bus_oe,
   input logic              chk_oe,
   input logic              mem_err_n,
   input logic              sgl_err,
   input logic              sgl_err_oe,
   input logic [ADDR_W-1:0] fail_addr,
   input logic              fail_valid
);

   // R11
   io_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cyc_valid && cyc_mem && cyc_rd) |-> (mem_err_n && !sgl_err));

   // R4
   sgl_not_multi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sgl_err |-> mem_err_n);

   // R8
   drive_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> $past(ram_off && cyc_valid && cyc_mem && cyc_rd));

   // R10
   fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_valid && !(ctl_we && ctl_clr_fail)) |=> (fail_valid && $stable(fail_addr)));

   // R6
   chk_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chk_oe |-> (cyc_valid && cyc_mem && !cyc_rd));

   // R2
   sgl_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sgl_err_oe |-> !sgl_err);

endmodule

bind mem_ecc_guard mem_ecc_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ctl_we       (ctl_we),
   .ctl_clr_fail (ctl_clr_fail),
   .cyc_valid    (cyc_valid),
   .cyc_mem      (cyc_mem),
   .cyc_rd       (cyc_rd),
   .ram_off      (ram_off),
   .bus_oe       (bus_oe),
   .chk_oe       (chk_oe),
   .mem_err_n    (mem_err_n),
   .sgl_err      (sgl_err),
   .sgl_err_oe   (sgl_err_oe),
   .fail_addr    (fail_addr),
   .fail_valid   (fail_valid)
);

// File: tb/sim_mem_ecc_guard.sv
`timescale 1ns/1ps
module sim_mem_ecc_guard;

   localparam int DW = 16;
   localparam int AW = 20;
   localparam int CW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ctl_we = 1'b0;
   logic [1:0]    ctl_mode = 2'b00;
   logic          ctl_clr_fail = 1'b0;
   logic          cyc_valid = 1'b0, cyc_mem = 1'b0, cyc_rd = 1'b0;
   logic [AW-1:0] cyc_addr = '0;
   logic          ram_off = 1'b0;
   logic [DW-1:0] bus_in = '0;
   logic [DW-1:0] bus_out;
   logic          bus_oe;
   logic [CW-1:0] chk_in = '0;
   logic [CW-1:0] chk_out;
   logic          chk_oe, mem_err_n, sgl_err, sgl_err_oe, fail_valid;
   logic [DW-1:0] diag_word;
   logic [AW-1:0] fail_addr;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   mem_ecc_guard #(.DATA_W(DW), .ADDR_W(AW)) u0 (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Reference code built from the position rule in R3.
   function automatic logic [5:0] ref_chk(input logic [15:0] d);
      logic [21:1] cw;
      logic [5:0]  c;
      int          k;
      cw = '0;
      k = 0;
      for (int p = 1; p <= 21; p++) begin
         if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16) begin
            cw[p] = d[k];
            k++;
         end
      end
      c = '0;
      for (int i = 0; i < 5; i++)
         for (int p = 1; p <= 21; p++)
            if (((p >> i) & 1) == 1) c[i] = c[i] ^ cw[p];
      c[5] = (^d) ^ (^c[4:0]);
      return c;
   endfunction

   task automatic ctl_write(input logic [1:0] m, input logic clr);
      @(negedge clk);
      ctl_we = 1'b1; ctl_mode = m; ctl_clr_fail = clr;
      @(negedge clk);
      ctl_we = 1'b0; ctl_clr_fail = 1'b0;
   endtask

   // Drive a cycle at a falling edge; sample combinational outputs 5 ns later.
   task automatic drive(input logic mem, input logic rd, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic [CW-1:0] c, input logic off);
      @(negedge clk);
      cyc_valid = 1'b1; cyc_mem = mem; cyc_rd = rd; cyc_addr = a;
      bus_in = d; chk_in = c; ram_off = off;
      #5;
   endtask

   task automatic idle();
      @(negedge clk);
      cyc_valid = 1'b0; ram_off = 1'b0;
   endtask

   task automatic after_edge();
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      #5;
      chk("R1 mem_err_n in reset", 32'(mem_err_n), 1);
      chk("R1 bus_oe in reset", 32'(bus_oe), 0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #2;
      chk("R1 sgl_err_oe after reset", 32'(sgl_err_oe), 0);
      chk("R1 fail_valid after reset", 32'(fail_valid), 0);
      drive(1, 0, 20'h1, 16'hA5A5, '0, 0);
      chk("R1 chk_oe off after reset", 32'(chk_oe), 0);
      idle();
   endtask

   task automatic t_off_mode();
      drive(1, 1, 20'h10, 16'h1234, 6'h3F, 0);
      chk("R11 off mode mem_err_n", 32'(mem_err_n), 1);
      chk("R11 off mode sgl_err", 32'(sgl_err), 0);
      after_edge();
      chk("R11 off mode no capture", 32'(fail_valid), 0);
      idle();
   endtask

   task automatic t_edac_write();
      logic [15:0] pats [4] = '{16'h0000, 16'hFFFF, 16'h8001, 16'h5A3C};
      ctl_write(2'b01, 1'b0);
      #2;
      chk("R2 sgl_err_oe in EDAC", 32'(sgl_err_oe), 1);
      foreach (pats[i]) begin
         drive(1, 0, 20'h20, pats[i], '0, 0);
         chk("R3 chk_oe on write", 32'(chk_oe), 1);
         chk("R3 check bits", 32'(chk_out), 32'(ref_chk(pats[i])));
      end
      idle();
   endtask

   task automatic t_edac_clean();
      drive(1, 1, 20'h30, 16'h5A3C, ref_chk(16'h5A3C), 0);
      chk("R4 clean read sgl_err", 32'(sgl_err), 0);
      chk("R5 clean read mem_err_n", 32'(mem_err_n), 1);
      after_edge();
      chk("R10 clean read no capture", 32'(fail_valid), 0);
      idle();
   endtask

   task automatic t_edac_single();
      logic [15:0] d = 16'hC3E1;
      drive(1, 1, 20'h4_1111, d ^ 16'h0400, ref_chk(d), 0);
      chk("R4 data flip sgl_err", 32'(sgl_err), 1);
      chk("R4 data flip mem_err_n", 32'(mem_err_n), 1);
      after_edge();
      chk("R9 diag after data flip", 32'(diag_word), 32'(d));
      chk("R10 first capture valid", 32'(fail_valid), 1);
      chk("R10 first capture addr", 32'(fail_addr), 32'h4_1111);
      // Flip the overall bit, then a Hamming check bit, at other addresses.
      d = 16'h0F0F;
      drive(1, 1, 20'h5_2222, d, ref_chk(d) ^ 6'h20, 0);
      chk("R4 overall bit flip sgl_err", 32'(sgl_err), 1);
      after_edge();
      chk("R9 diag after check flip", 32'(diag_word), 32'(d));
      chk("R10 later failure ignored", 32'(fail_addr), 32'h4_1111);
      drive(1, 1, 20'h5_2223, 16'h0001, ref_chk(16'h0001) ^ 6'h04, 0);
      chk("R4 check bit 2 flip sgl_err", 32'(sgl_err), 1);
      after_edge();
      chk("R9 diag keeps data", 32'(diag_word), 32'h0001);
      idle();
   endtask

   task automatic t_edac_double();
      logic [15:0] d = 16'h7E81;
      drive(1, 1, 20'h6_3333, d ^ 16'h0009, ref_chk(d), 0);
      chk("R5 double mem_err_n", 32'(mem_err_n), 0);
      chk("R5 double sgl_err", 32'(sgl_err), 0);
      after_edge();
      chk("R9 diag unchanged on double", 32'(diag_word), 32'h0001);
      chk("R10 still first addr", 32'(fail_addr), 32'h4_1111);
      drive(0, 1, 20'h6_4444, d ^ 16'h0009, ref_chk(d), 0);
      chk("R11 I/O read mem_err_n", 32'(mem_err_n), 1);
      chk("R11 I/O read sgl_err", 32'(sgl_err), 0);
      idle();
      ctl_write(2'b01, 1'b1);
      #2;
      chk("R10 cleared", 32'(fail_valid), 0);
      drive(0, 1, 20'h6_5555, d ^ 16'h0009, ref_chk(d), 0);
      after_edge();
      chk("R11 I/O read no capture", 32'(fail_valid), 0);
      drive(1, 1, 20'h7_7777, d ^ 16'h8001, ref_chk(d), 0);
      after_edge();
      chk("R10 capture after clear", 32'(fail_addr), 32'h7_7777);
      idle();
   endtask

   task automatic t_drive();
      logic [15:0] d = 16'hBEEF;
      drive(1, 1, 20'h8, d ^ 16'h0100, ref_chk(d), 1);
      chk("R8 no drive during request", 32'(bus_oe), 0);
      after_edge();
      chk("R8 drive after request", 32'(bus_oe), 1);
      chk("R8 corrected word driven", 32'(bus_out), 32'(d));
      idle();
      after_edge();
      chk("R8 drive released", 32'(bus_oe), 0);
   endtask

   task automatic t_parity(input logic odd);
      logic [15:0] d = 16'h0007;
      logic        pb;
      pb = (^d) ^ odd;
      ctl_write(odd ? 2'b11 : 2'b10, 1'b1);
      #2;
      chk("R2 sgl_err_oe off in parity", 32'(sgl_err_oe), 0);
      drive(1, 0, 20'h9, d, '0, 0);
      chk("R6 parity chk_oe", 32'(chk_oe), 1);
      chk("R6 parity chk_out", 32'(chk_out), 32'(pb));
      drive(1, 1, 20'hA, d, {5'b10101, pb}, 0);
      chk("R7 good parity accepted", 32'(mem_err_n), 1);
      drive(1, 1, 20'hB, d, {5'b01010, ~pb}, 0);
      chk("R7 bad parity flagged", 32'(mem_err_n), 0);
      chk("R7 no sgl_err in parity", 32'(sgl_err), 0);
      after_edge();
      chk("R10 parity failure captured", 32'(fail_addr), 32'hB);
      idle();
   endtask

   initial begin
      t_reset();
      t_off_mode();
      t_edac_write();
      t_edac_clean();
      t_edac_single();
      t_edac_double();
      t_drive();
      t_parity(1'b0);
      t_parity(1'b1);
      repeat (2) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule